// File: doc/BRIEF.md
# Burst Cache Access Sequencer

This block paces four-beat burst transfers to a pipelined burst secondary cache. A requester presents an address, a bank number and a read/write flag for one cycle. The sequencer first checks the address against a set of programmable non-cacheable windows. On a hit it reports a bypass and runs no beats. On a miss it reports a cacheable access and then raises one ready strobe per beat.

The first beat of a burst carries the addressing and precharge overhead, so it is slower than the three beats after it. When a read burst follows another burst with no idle cycle between them, part of that overhead is hidden. It is hidden partly when the new read targets the other bank and almost fully when it targets the same bank. Each window is described by a base, a power-of-two size and an enable. Each window also has a flag that tells the memory side to keep local memory out of that range.

Top module: `burst_cache_seq`

## Requirements
- R1: While reset is high and in the cycle after it is released, beat_rdy, burst_done, beat_idx, acc_cached, acc_bypass and acc_local_off are all zero.
- R2: A cacheable burst accepted in cycle n when it is not back to back, whether read or write, raises beat_rdy in cycles n+3, n+4, n+5 and n+6 (a 3-1-1-1 pattern).
- R3: beat_idx counts 0, 1, 2, 3 across the four ready cycles of a burst. burst_done is high only together with the ready for beat index 3.
- R4: A read accepted in the cycle right after the previous burst's last beat, to a bank number different from that burst's bank, raises beat_rdy in cycles n+2 to n+5.
- R5: A read accepted in the cycle right after the previous burst's last beat, to the same bank number, raises beat_rdy in cycles n+1 to n+4.
- R6: A write never gets a shortened first beat, even when it follows a burst back to back; its readies fall in n+3 to n+6.
- R7: A read that follows a burst after one or more idle cycles uses the R2 timing.
- R8: A request raised while a burst is waiting or transferring, including during its last-beat cycle, is ignored: it produces no extra ready, flag or burst.
- R9: Window k matches when cfg_en[k] is 1 and address bits at and above position cfg_size_log2[k] equal those of cfg_base[k]. A request that matches any window pulses acc_bypass in cycle n+1 and raises no beat_rdy. acc_local_off is pulsed in that same cycle when cfg_local_off is 1 for a matching window.
- R10: A request that matches no enabled window, including one whose address falls inside a disabled window, pulses acc_cached in cycle n+1 and starts a burst.
- R11: A bypassed request gives no back-to-back credit. A read accepted in the cycle after a bypass uses R2 timing, even when that bypass came in the cycle right after a burst's last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Burst request, sampled when the sequencer is idle |
| req_addr | input | ADDR_W | Request address used for the window check |
| req_bank | input | BANK_W | Cache bank targeted by the request |
| req_write | input | 1 | 1 for a write burst, 0 for a read burst |
| cfg_en | input | NREG | Enable per non-cacheable window |
| cfg_base | input | NREG x ADDR_W | Base address per window, aligned to its size |
| cfg_size_log2 | input | NREG x SZ_W | Log2 of each window's size in bytes |
| cfg_local_off | input | NREG | Per-window flag that local memory is disabled inside it |
| beat_rdy | output | 1 | One pulse per transferred beat |
| beat_idx | output | 2 | Index of the current beat while beat_rdy is high |
| burst_done | output | 1 | High with the last beat of a burst |
| acc_cached | output | 1 | One-cycle pulse: request accepted as cacheable |
| acc_bypass | output | 1 | One-cycle pulse: request hit a non-cacheable window |
| acc_local_off | output | 1 | One-cycle pulse with acc_bypass when a hit window disables local memory |

## Verification
The flag pulses are due exactly one cycle after the request cycle. The first ready is due one, two or three cycles after the request, depending on the back-to-back case, and the other beats follow on consecutive cycles. The bench drives each request at a falling edge and then samples every following falling edge. It compares the whole ready/done/index vector against a window computed from the expected latency, so a pulse that comes one cycle early or late fails the check. Chains of bursts are issued with no idle cycle so that the next request lands exactly in the cycle after the last beat. The quiet phases after an ignored or bypassed request check that nothing appears later.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    localparam int BEATS  = 4;
    localparam int BEAT_W = $clog2(BEATS);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_BEAT
    } seq_state_e;

    typedef struct packed {
        logic hit;
        logic local_off;
    } win_res_t;

    // Clocks spent on the first beat of a burst.
    function automatic int unsigned first_beat_lat(
        input logic        chained,
        input logic        is_write,
        input logic        same_bank,
        input int unsigned iso_lat,
        input int unsigned xbank_lat,
        input int unsigned sbank_lat
    );
        if (!chained || is_write) return iso_lat;
        if (same_bank)            return sbank_lat;
        return xbank_lat;
    endfunction

endpackage

// File: rtl/bcs_window_match.sv
module bcs_window_match
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SZ_W   = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              en,
    input  logic [ADDR_W-1:0] base,
    input  logic [SZ_W-1:0]   size_log2,
    input  logic              local_off,
    output win_res_t          res
);
    logic [ADDR_W-1:0] keep_mask;
    logic              match;

    assign keep_mask = {ADDR_W{1'b1}} << size_log2;
    assign match     = en && (((addr ^ base) & keep_mask) == '0);

    always_comb begin
        res.hit       = match;
        res.local_off = match && local_off;
    end
endmodule

// File: rtl/bcs_lat_sel.sv
module bcs_lat_sel
    import bcs_pkg::*;
#(
    parameter int BANK_W    = 1,
    parameter int LAT_W     = 2,
    parameter int ISO_LAT   = 3,
    parameter int XBANK_LAT = 2,
    parameter int SBANK_LAT = 1
) (
    input  logic              chained,
    input  logic              is_write,
    input  logic [BANK_W-1:0] bank,
    input  logic [BANK_W-1:0] prev_bank,
    output logic [LAT_W-1:0]  lat
);
    int unsigned lat_full;

    always_comb begin
        lat_full = first_beat_lat(chained, is_write, bank == prev_bank,
                                  ISO_LAT, XBANK_LAT, SBANK_LAT);
        lat      = LAT_W'(lat_full);
    end
endmodule

// File: rtl/bcs_beat_engine.sv
module bcs_beat_engine
    import bcs_pkg::*;
#(
    parameter int LAT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LAT_W-1:0]  lat,
    output logic              idle,
    output logic              beat_rdy,
    output logic [BEAT_W-1:0] beat_idx,
    output logic              burst_done
);
    localparam logic [BEAT_W-1:0] LAST_IDX = BEAT_W'(BEATS - 1);

    seq_state_e        st_q;
    logic [LAT_W-1:0]  wait_q;
    logic [BEAT_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            wait_q <= '0;
            idx_q  <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        idx_q <= '0;
                        if (lat <= LAT_W'(1)) begin
                            st_q <= ST_BEAT;
                        end else begin
                            st_q   <= ST_WAIT;
                            wait_q <= lat - LAT_W'(1);
                        end
                    end
                end
                ST_WAIT: begin
                    if (wait_q <= LAT_W'(1)) st_q <= ST_BEAT;
                    else                     wait_q <= wait_q - LAT_W'(1);
                end
                ST_BEAT: begin
                    idx_q <= idx_q + BEAT_W'(1);
                    if (idx_q == LAST_IDX) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign idle       = (st_q == ST_IDLE);
    assign beat_rdy   = (st_q == ST_BEAT);
    assign beat_idx   = beat_rdy ? idx_q : '0;
    assign burst_done = beat_rdy && (idx_q == LAST_IDX);
endmodule

// File: rtl/burst_cache_seq.sv
module burst_cache_seq
    import bcs_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NREG      = 2,
    parameter int BANKS     = 2,
    parameter int ISO_LAT   = 3,
    parameter int XBANK_LAT = 2,
    parameter int SBANK_LAT = 1,
    localparam int SZ_W     = $clog2(ADDR_W + 1),
    localparam int BANK_W   = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [BANK_W-1:0]          req_bank,
    input  logic                       req_write,
    input  logic [NREG-1:0]            cfg_en,
    input  logic [NREG-1:0][ADDR_W-1:0] cfg_base,
    input  logic [NREG-1:0][SZ_W-1:0]  cfg_size_log2,
    input  logic [NREG-1:0]            cfg_local_off,
    output logic                       beat_rdy,
    output logic [BEAT_W-1:0]          beat_idx,
    output logic                       burst_done,
    output logic                       acc_cached,
    output logic                       acc_bypass,
    output logic                       acc_local_off
);
    localparam int LAT_W = $clog2(ISO_LAT + 1);

    win_res_t [NREG-1:0] win_res;
    logic [NREG-1:0]     win_hit;
    logic [NREG-1:0]     win_loc;

    for (genvar g = 0; g < NREG; g++) begin : g_win
        bcs_window_match #(
            .ADDR_W (ADDR_W),
            .SZ_W   (SZ_W)
        ) u_win (
            .addr      (req_addr),
            .en        (cfg_en[g]),
            .base      (cfg_base[g]),
            .size_log2 (cfg_size_log2[g]),
            .local_off (cfg_local_off[g]),
            .res       (win_res[g])
        );
        assign win_hit[g] = win_res[g].hit;
        assign win_loc[g] = win_res[g].local_off;
    end

    logic              eng_idle;
    logic              accept;
    logic              start;
    logic              any_hit;
    logic              chained_q;
    logic [BANK_W-1:0] prev_bank_q;
    logic [LAT_W-1:0]  lat;

    assign any_hit = |win_hit;
    assign accept  = req_valid && eng_idle;
    assign start   = accept && !any_hit;

    bcs_lat_sel #(
        .BANK_W    (BANK_W),
        .LAT_W     (LAT_W),
        .ISO_LAT   (ISO_LAT),
        .XBANK_LAT (XBANK_LAT),
        .SBANK_LAT (SBANK_LAT)
    ) u_lat (
        .chained   (chained_q),
        .is_write  (req_write),
        .bank      (req_bank),
        .prev_bank (prev_bank_q),
        .lat       (lat)
    );

    bcs_beat_engine #(
        .LAT_W (LAT_W)
    ) u_eng (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .lat        (lat),
        .idle       (eng_idle),
        .beat_rdy   (beat_rdy),
        .beat_idx   (beat_idx),
        .burst_done (burst_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            chained_q     <= 1'b0;
            prev_bank_q   <= '0;
            acc_cached    <= 1'b0;
            acc_bypass    <= 1'b0;
            acc_local_off <= 1'b0;
        end else begin
            chained_q     <= burst_done;
            if (start) prev_bank_q <= req_bank;
            acc_cached    <= start;
            acc_bypass    <= accept && any_hit;
            acc_local_off <= accept && (|win_loc);
        end
    end
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              beat_rdy,
    input logic [BEAT_W-1:0] beat_idx,
    input logic              burst_done,
    input logic              acc_cached,
    input logic              acc_bypass,
    input logic              acc_local_off
);
    localparam logic [BEAT_W-1:0] TOP_IDX = '1;

    // R3
    done_with_last_chk: assert property (@(posedge clk) disable iff (rst)
        burst_done |-> (beat_rdy && beat_idx == TOP_IDX));

    // R3
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_rdy && beat_idx != TOP_IDX) |=>
            (beat_rdy && beat_idx == $past(beat_idx) + BEAT_W'(1)));

    // R8
    gap_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        burst_done |=> !beat_rdy);

    // R9
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(acc_bypass && acc_cached));

    // R9
    local_needs_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        acc_local_off |-> acc_bypass);

    // R10
    one_flag_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        acc_cached |=> !acc_cached);
endmodule

bind burst_cache_seq bcs_checker #(
    .BEAT_W (bcs_pkg::BEAT_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .beat_rdy      (beat_rdy),
    .beat_idx      (beat_idx),
    .burst_done    (burst_done),
    .acc_cached    (acc_cached),
    .acc_bypass    (acc_bypass),
    .acc_local_off (acc_local_off)
);

// File: tb/tb_burst_cache_seq.sv
module tb_burst_cache_seq;
    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic [31:0]      req_addr = '0;
    logic [0:0]       req_bank = '0;
    logic             req_write = 1'b0;
    logic [1:0]       cfg_en;
    logic [1:0][31:0] cfg_base;
    logic [1:0][5:0]  cfg_size_log2;
    logic [1:0]       cfg_local_off;
    logic             beat_rdy;
    logic [1:0]       beat_idx;
    logic             burst_done;
    logic             acc_cached;
    logic             acc_bypass;
    logic             acc_local_off;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_cache_seq dut (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_addr      (req_addr),
        .req_bank      (req_bank),
        .req_write     (req_write),
        .cfg_en        (cfg_en),
        .cfg_base      (cfg_base),
        .cfg_size_log2 (cfg_size_log2),
        .cfg_local_off (cfg_local_off),
        .beat_rdy      (beat_rdy),
        .beat_idx      (beat_idx),
        .burst_done    (burst_done),
        .acc_cached    (acc_cached),
        .acc_bypass    (acc_bypass),
        .acc_local_off (acc_local_off)
    );

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // Issue one request at a falling edge and check every cycle up to the last beat.
    // lat == 0 means a bypass is expected. poke[i] raises req_valid again in cycle n+i.
    task automatic run_req(input logic [31:0] addr, input logic bank, input logic wr,
                           input int lat, input logic exp_loc, input logic [7:0] poke,
                           input string tag);
        int last;
        logic [7:0] act, exp;
        last = (lat == 0) ? 1 : lat + 3;
        req_addr  = addr;
        req_bank  = bank;
        req_write = wr;
        req_valid = 1'b1;
        for (int i = 1; i <= last; i++) begin
            @(negedge clk);
            req_valid = poke[i];
            if (i == 1) begin
                act = {5'b0, acc_cached, acc_bypass, acc_local_off};
                exp = {5'b0, (lat != 0), (lat == 0), (lat == 0) && exp_loc};
                chk(act == exp, {tag, " flags"}, act, exp);
            end
            act = {4'b0, beat_rdy, burst_done, beat_idx};
            if (lat != 0 && i >= lat && i <= lat + 3)
                exp = {4'b0, 1'b1, (i == lat + 3), 2'(i - lat)};
            else
                exp = 8'h00;
            chk(act == exp, {tag, " beats"}, act, exp);
        end
        if (lat != 0) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    task automatic quiet(input int n, input string tag);
        logic [7:0] act;
        req_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            act = {3'b0, beat_rdy, burst_done, acc_cached, acc_bypass, acc_local_off};
            chk(act == 8'h00, {tag, " quiet"}, act, 8'h00);
        end
    endtask

    task automatic t_reset();
        logic [7:0] act;
        repeat (3) @(posedge clk);
        @(negedge clk);
        act = {2'b0, beat_rdy, burst_done, beat_idx, acc_cached, acc_bypass};
        chk(act == 8'h00 && !acc_local_off, "R1 in reset", act, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        act = {2'b0, beat_rdy, burst_done, beat_idx, acc_cached, acc_bypass};
        chk(act == 8'h00 && !acc_local_off, "R1 after release", act, 8'h00);
    endtask

    task automatic t_isolated();
        run_req(32'h0000_1000, 1'b0, 1'b0, 3, 1'b0, 8'h00, "R2 read");
        quiet(2, "R2");
        run_req(32'h0000_2000, 1'b1, 1'b1, 3, 1'b0, 8'h00, "R2 write R3");
        quiet(2, "R3");
    endtask

    task automatic t_chain();
        run_req(32'h0000_3000, 1'b0, 1'b0, 3, 1'b0, 8'h00, "R2 chain head");
        run_req(32'h0000_3040, 1'b1, 1'b0, 2, 1'b0, 8'h00, "R4 other bank");
        run_req(32'h0000_3080, 1'b1, 1'b0, 1, 1'b0, 8'h00, "R5 same bank");
        run_req(32'h0000_30c0, 1'b1, 1'b1, 3, 1'b0, 8'h00, "R6 write");
        run_req(32'h0000_3100, 1'b1, 1'b0, 1, 1'b0, 8'h00, "R5 after write");
        quiet(1, "R7");
        run_req(32'h0000_3140, 1'b1, 1'b0, 3, 1'b0, 8'h00, "R7 gap");
        quiet(3, "R7");
    endtask

    task automatic t_busy();
        // extra requests in cycle n+2 (waiting) and n+6 (last beat)
        run_req(32'h0000_5000, 1'b0, 1'b0, 3, 1'b0, 8'b0100_0100, "R8 busy");
        quiet(8, "R8");
    endtask

    task automatic t_windows();
        run_req(32'h000A_1234, 1'b0, 1'b0, 0, 1'b1, 8'h00, "R9 win0");
        quiet(3, "R9");
        run_req(32'h00F8_0000, 1'b0, 1'b1, 0, 1'b0, 8'h00, "R9 win1");
        quiet(3, "R9");
        run_req(32'h000C_0000, 1'b0, 1'b0, 3, 1'b0, 8'h00, "R10 above win0");
        quiet(2, "R10");
        run_req(32'h0009_FFFF, 1'b0, 1'b0, 3, 1'b0, 8'h00, "R10 below win0");
        quiet(2, "R10");
        cfg_en = 2'b01;
        run_req(32'h00F8_0000, 1'b0, 1'b0, 3, 1'b0, 8'h00, "R10 disabled win1");
        quiet(2, "R10");
        cfg_en = 2'b11;
    endtask

    task automatic t_bypass_credit();
        run_req(32'h0000_7000, 1'b0, 1'b0, 3, 1'b0, 8'h00, "R11 head");
        run_req(32'h000A_0000, 1'b0, 1'b0, 0, 1'b1, 8'h00, "R11 bypass");
        run_req(32'h0000_7040, 1'b0, 1'b0, 3, 1'b0, 8'h00, "R11 after bypass");
        quiet(3, "R11");
    endtask

    initial begin
        cfg_en           = 2'b11;
        cfg_base[0]      = 32'h000A_0000;
        cfg_size_log2[0] = 6'd17;
        cfg_local_off[0] = 1'b1;
        cfg_base[1]      = 32'h00F0_0000;
        cfg_size_log2[1] = 6'd20;
        cfg_local_off[1] = 1'b0;
        t_reset();
        t_isolated();
        t_chain();
        t_busy();
        t_windows();
        t_bypass_credit();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule